// File: doc/BRIEF.md
# I/O Address Translation Unit

This block maps the addresses issued by DMA masters on an I/O bus onto physical memory. Translation covers one window at the top of the 32-bit space, whose size a 3-bit code selects. Each 4 KB page in that window has a 32-bit descriptor in a table in memory, and an eight-entry fully associative cache holds recently used descriptors. On a cache miss the unit stalls the requester, reads the descriptor through a simple request/ready port whose data returns a fixed number of cycles later, and then answers.

Software controls the block through a small word-addressed register port. Register 0 holds the enable bit, the window code and the read-only identity codes. Register 1 holds the table base. A write to register 2 empties the whole cache, and a write to register 3 drops one page from it. Registers 8 onward hold one configuration word per slot. A slot can be set to pass its addresses through untranslated, and in that case a configuration bit supplies physical bit 30. Each request returns a one-cycle acknowledge carrying the physical address, a cacheable flag and a fault flag. A fault reports an address below the window, a descriptor marked invalid, or a write to a page that is not writable.

Top module: `io_xlate_unit`

## Requirements
- R1: After reset, register 0 reads 0x32000000 (identity codes 3 and 2, enable 0, window code 0), the table base and all slot words read 0, and xl_ack and mem_req are low.
- R2: Register 0 keeps the enable in bit 0 and the window code in bits 4:2. Bits 31:28 always read the implementation code 3 and bits 27:24 the version code 2. Every other bit reads 0.
- R3: Slot word s sits at register 8+s. Only bits 16, 2, 1 and 0 are kept and the rest read 0. Bits 1 and 2 are storage only and do not change a translation.
- R4: If bit 0 of the requesting slot's word is set, the response arrives one cycle after acceptance, with no fault and no table read. Its address is {0, slot bit 16, vaddr[29:0]}. Bypass takes precedence over every other check.
- R5: With the enable bit clear and no bypass, the address is returned unchanged, with no fault and no table read.
- R6: Window code c spans 0xFFFFFFFF down to 2^32 - 2^(24+c). An enabled request below that span faults in one cycle and reads nothing.
- R7: On a miss the unit reads the descriptor at table base + 4 × ((vaddr - window base) >> 12). It holds that address until mem_ready and samples mem_rdata exactly MEM_LAT cycles after the handshake. The physical address is {0, entry[26:8], vaddr[11:0]} and the cacheable flag is entry bit 7.
- R8: A descriptor whose bit 1 (valid) is clear faults and is not cached. A write to a page whose bit 2 (writable) is clear faults, whether the descriptor comes from memory or from the cache. A faulting response carries address 0 and cacheable 0.
- R9: A request that hits in the cache is answered one cycle after acceptance without a table read.
- R10: Any write to register 2 empties the cache, whatever data is written.
- R11: A write to register 3 drops only the cached page whose number equals data bits 31:12. Data bits 11:0 are ignored.
- R12: Valid descriptors fill the eight entries in round-robin order, so a ninth new page evicts the entry that was filled earliest.
- R13: A flush in the same cycle as a fill cancels the fill if it is a whole-cache flush or names the page being filled. The response still carries the fetched translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| xl_req | input | 1 | Translation request, held until xl_ack |
| xl_vaddr | input | 32 | I/O virtual address |
| xl_write | input | 1 | Request is a write |
| xl_slot | input | $clog2(NUM_SLOTS) | Requesting slot |
| xl_ack | output | 1 | One-cycle response strobe |
| xl_paddr | output | 32 | Physical address |
| xl_fault | output | 1 | Translation fault |
| xl_cache | output | 1 | Page is cacheable |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor address |
| mem_ready | input | 1 | Read request accepted |
| mem_rdata | input | 32 | Descriptor data, MEM_LAT cycles after the handshake |

## Verification
A descriptor fill and a flush write can land on the same clock edge. The bench produces this by writing the flush register in the cycle just before the edge on which its memory model presents the descriptor. It checks that the response still carries the fetched translation. It then repeats the same address and counts table reads to see whether the entry was kept. That is a new read after a matching page flush or a whole-cache flush, and a hit after a flush of some other page.

// File: rtl/io_xlate_unit.sv
module io_xlate_unit #(
  parameter int NUM_SLOTS   = 4,
  parameter int TLB_ENTRIES = 8,
  parameter int MEM_LAT     = 2,
  parameter logic [3:0] IMPL_ID = 4'h3,
  parameter logic [3:0] VER_ID  = 4'h2,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              xl_req,
  input  logic [31:0]       xl_vaddr,
  input  logic              xl_write,
  input  logic [SLOT_W-1:0] xl_slot,
  output logic              xl_ack,
  output logic [31:0]       xl_paddr,
  output logic              xl_fault,
  output logic              xl_cache,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata
);
  localparam int PTR_W = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;
  localparam int CNT_W = $clog2(MEM_LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT} st_t;
  st_t st;

  logic        ctl_en;
  logic [2:0]  ctl_rng;
  logic [29:0] tbl_base;
  logic [3:0]  scfg [NUM_SLOTS];

  logic [TLB_ENTRIES-1:0] t_vld, t_wr, t_cc;
  logic [19:0] t_vpn [TLB_ENTRIES];
  logic [18:0] t_ppn [TLB_ENTRIES];
  logic [PTR_W-1:0] rr;

  logic [CNT_W-1:0] cnt;
  logic [31:0] q_va;
  logic        q_wr;

  logic        r_ack, r_fault, r_cc;
  logic [31:0] r_pa;

  logic wr_ctl, wr_base, wr_fall, wr_fpg;
  assign wr_ctl  = reg_wr && reg_addr == 4'd0;
  assign wr_base = reg_wr && reg_addr == 4'd1;
  assign wr_fall = reg_wr && reg_addr == 4'd2;
  assign wr_fpg  = reg_wr && reg_addr == 4'd3;

  logic [31:0] win_base;
  logic        in_win;
  logic [19:0] off_pg;
  assign win_base = 32'hFFFF_FFFF << (5'd24 + {2'b00, ctl_rng});
  assign in_win   = &(xl_vaddr | ~win_base);
  assign off_pg   = q_va[31:12] & ~win_base[31:12];
  assign mem_addr = {tbl_base, 2'b00} + {10'd0, off_pg, 2'b00};
  assign mem_req  = (st == S_FETCH);

  logic [3:0] byp_cfg;
  assign byp_cfg = scfg[xl_slot];

  logic             hit;
  logic [PTR_W-1:0] hidx;
  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = 0; i < TLB_ENTRIES; i++)
      if (t_vld[i] && t_vpn[i] == xl_vaddr[31:12]) begin
        hit  = 1'b1;
        hidx = PTR_W'(i);
      end
  end

  logic hit_flt, fetch_done, pte_flt, kill_fill, do_fill;
  assign hit_flt    = xl_write && !t_wr[hidx];
  assign fetch_done = (st == S_WAIT) && cnt == CNT_W'(MEM_LAT);
  assign pte_flt    = !mem_rdata[1] || (q_wr && !mem_rdata[2]);
  assign kill_fill  = wr_fall || (wr_fpg && reg_wdata[31:12] == q_va[31:12]);
  assign do_fill    = fetch_done && mem_rdata[1] && !kill_fill;

  logic unused_bits;
  assign unused_bits = ^{mem_rdata[31:27], mem_rdata[6:3], mem_rdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_rng  <= 3'd0;
      tbl_base <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) scfg[s] <= 4'd0;
    end else begin
      if (wr_ctl) begin
        ctl_en  <= reg_wdata[0];
        ctl_rng <= reg_wdata[4:2];
      end
      if (wr_base) tbl_base <= reg_wdata[31:2];
      for (int s = 0; s < NUM_SLOTS; s++)
        if (reg_wr && reg_addr == 4'(8 + s)) scfg[s] <= {reg_wdata[16], reg_wdata[2:0]};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0:    reg_rdata = {IMPL_ID, VER_ID, 19'd0, ctl_rng, 1'b0, ctl_en};
      4'd1:    reg_rdata = {tbl_base, 2'b00};
      default: reg_rdata = '0;
    endcase
    for (int s = 0; s < NUM_SLOTS; s++)
      if (reg_addr == 4'(8 + s)) reg_rdata = {15'd0, scfg[s][3], 13'd0, scfg[s][2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      q_va    <= '0;
      q_wr    <= 1'b0;
      r_ack   <= 1'b0;
      r_pa    <= '0;
      r_fault <= 1'b0;
      r_cc    <= 1'b0;
    end else begin
      r_ack <= 1'b0;
      case (st)
        S_IDLE: if (xl_req) begin
          q_va <= xl_vaddr;
          q_wr <= xl_write;
          if (byp_cfg[0]) begin
            r_ack <= 1'b1; r_fault <= 1'b0; r_cc <= 1'b0;
            r_pa  <= {1'b0, byp_cfg[3], xl_vaddr[29:0]};
          end else if (!ctl_en) begin
            r_ack <= 1'b1; r_fault <= 1'b0; r_cc <= 1'b0;
            r_pa  <= xl_vaddr;
          end else if (!in_win) begin
            r_ack <= 1'b1; r_fault <= 1'b1; r_cc <= 1'b0;
            r_pa  <= '0;
          end else if (hit) begin
            r_ack   <= 1'b1;
            r_fault <= hit_flt;
            r_cc    <= !hit_flt && t_cc[hidx];
            r_pa    <= hit_flt ? 32'd0 : {1'b0, t_ppn[hidx], xl_vaddr[11:0]};
          end else begin
            st <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ready) begin
          st  <= S_WAIT;
          cnt <= CNT_W'(1);
        end
        S_WAIT: if (fetch_done) begin
          st      <= S_IDLE;
          r_ack   <= 1'b1;
          r_fault <= pte_flt;
          r_cc    <= !pte_flt && mem_rdata[7];
          r_pa    <= pte_flt ? 32'd0 : {1'b0, mem_rdata[26:8], q_va[11:0]};
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_vld <= '0;
      rr    <= '0;
    end else begin
      for (int i = 0; i < TLB_ENTRIES; i++) begin
        if (wr_fall) t_vld[i] <= 1'b0;
        else if (do_fill && rr == PTR_W'(i)) t_vld[i] <= 1'b1;
        else if (wr_fpg && t_vpn[i] == reg_wdata[31:12]) t_vld[i] <= 1'b0;
      end
      if (do_fill) rr <= rr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      t_vpn[rr] <= q_va[31:12];
      t_ppn[rr] <= mem_rdata[26:8];
      t_wr[rr]  <= mem_rdata[2];
      t_cc[rr]  <= mem_rdata[7];
    end
  end

  assign xl_ack   = r_ack;
  assign xl_paddr = r_pa;
  assign xl_fault = r_fault;
  assign xl_cache = r_cc;

  assert_fetch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

  assert_flush_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall |=> t_vld == '0);

  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && xl_req && byp_cfg[0] |=> xl_ack && !xl_fault && !mem_req);

  assert_below_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && xl_req && !byp_cfg[0] && ctl_en && !in_win |=> xl_ack && xl_fault);

  assert_invalid_pte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done && !mem_rdata[1] |=> xl_ack && xl_fault && xl_paddr == 32'd0);
endmodule

// File: tb/tb_io_xlate_unit.sv
module tb_io_xlate_unit;
  localparam int LAT = 2;
  localparam logic [31:0] TBASE = 32'h0010_0000;
  localparam logic [31:0] WIN2  = 32'hFC00_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n = 1'b0;

  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xl_req = 1'b0;
  logic [31:0] xl_vaddr = '0;
  logic        xl_write = 1'b0;
  logic [1:0]  xl_slot = '0;
  logic        xl_ack, xl_fault, xl_cache, mem_req;
  logic [31:0] xl_paddr, mem_addr;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  io_xlate_unit #(.MEM_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_write(xl_write), .xl_slot(xl_slot),
    .xl_ack(xl_ack), .xl_paddr(xl_paddr), .xl_fault(xl_fault), .xl_cache(xl_cache),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0, fetches = 0, cd = 0, ncyc = 0;
  logic [31:0] saddr = '0;
  event data_ev;

  function automatic logic [31:0] pte(int idx);
    logic [18:0] ppn;
    ppn = 19'(idx * 3 + 32'h1234);
    return {5'd0, ppn, idx[0], 4'd0, (idx % 4) != 3, (idx % 8) != 5, 1'b0};
  endfunction

  always @(negedge clk) begin
    ncyc++;
    if (cd == 1) begin
      mem_rdata = pte(int'((saddr - TBASE) >> 2));
      -> data_ev;
    end else mem_rdata = 32'hFFFF_FFFD;
    mem_ready = (ncyc % 3) != 1;
    if (mem_req && mem_ready) begin
      cd = LAT; saddr = mem_addr; fetches++;
    end else if (cd > 0) cd--;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic xlate(logic [31:0] va, logic w, logic [1:0] s,
                       output logic [31:0] pa, output logic f, output logic c, output int lat);
    @(negedge clk); xl_req = 1'b1; xl_vaddr = va; xl_write = w; xl_slot = s; lat = 0;
    do begin @(negedge clk); lat++; end while (!xl_ack && lat < 100);
    pa = xl_paddr; f = xl_fault; c = xl_cache; xl_req = 1'b0;
  endtask

  task automatic xcheck(string tag, logic [31:0] va, logic w, logic [1:0] s,
                        logic exp_fetch, logic [31:0] wbase);
    logic [31:0] e, epa, pa; logic ef, ec, f, c; int lat, f0, idx;
    if (va < wbase) begin ef = 1'b1; epa = '0; ec = 1'b0; end
    else begin
      idx = int'((va - wbase) >> 12);
      e   = pte(idx);
      ef  = !e[1] || (w && !e[2]);
      epa = ef ? 32'd0 : {1'b0, e[26:8], va[11:0]};
      ec  = !ef && e[7];
    end
    f0 = fetches;
    xlate(va, w, s, pa, f, c, lat);
    chk({tag, " paddr"}, pa, epa);
    chk({tag, " fault"}, {31'd0, f}, {31'd0, ef});
    chk({tag, " cache"}, {31'd0, c}, {31'd0, ec});
    chk({tag, " table reads"}, fetches - f0, exp_fetch ? 1 : 0);
    if (!exp_fetch) chk({tag, " latency"}, lat, 1);
  endtask

  localparam logic [33:0] VEC [12] = '{
    {32'hFC00_0000, 1'b0, 1'b1}, {32'hFC00_0123, 1'b0, 1'b0},
    {32'hFC00_1ABC, 1'b1, 1'b1}, {32'hFC00_3004, 1'b1, 1'b1},
    {32'hFC00_3008, 1'b0, 1'b0}, {32'hFC00_5000, 1'b0, 1'b1},
    {32'hFC00_5010, 1'b0, 1'b1}, {32'hFBFF_FFFC, 1'b0, 1'b0},
    {32'hFFFF_F000, 1'b0, 1'b1}, {32'hFFFF_FFFF, 1'b1, 1'b0},
    {32'hFC00_1000, 1'b0, 1'b0}, {32'hFC00_3FFF, 1'b1, 1'b0}
  };
  localparam int RRK [9] = '{16, 17, 18, 19, 20, 22, 23, 24, 25};

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd, pa; logic f, c; int lat, f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rreg(4'd0, rd); chk("R1 ctrl", rd, 32'h3200_0000);
    rreg(4'd1, rd); chk("R1 base", rd, 32'h0);
    rreg(4'd8, rd); chk("R1 slot0", rd, 32'h0);
    chk("R1 ack", {31'd0, xl_ack}, 32'h0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'h0);

    // R2 control fields
    wreg(4'd0, 32'hFFFF_FFFF); rreg(4'd0, rd); chk("R2 ctrl readback", rd, 32'h3200_001D);
    wreg(4'd1, TBASE | 32'h3); rreg(4'd1, rd); chk("R7 base readback", rd, TBASE);
    wreg(4'd0, 32'h9);
    wreg(4'd2, 32'h0);

    // R7 R8 R9 vector walk, window code 2
    for (int i = 0; i < 12; i++)
      xcheck($sformatf("R7 R8 R9 vec%0d", i), VEC[i][33:2], VEC[i][1], 2'd0, VEC[i][0], WIN2);

    // R10 flush all, data ignored
    wreg(4'd2, 32'hDEAD_BEEF);
    xcheck("R10 refetch", 32'hFC00_0000, 1'b0, 2'd0, 1'b1, WIN2);

    // R11 page flush
    xcheck("R11 fill", 32'hFC00_1000, 1'b0, 2'd0, 1'b1, WIN2);
    wreg(4'd3, 32'hFC00_1ABC);
    xcheck("R11 other kept", 32'hFC00_0010, 1'b0, 2'd0, 1'b0, WIN2);
    xcheck("R11 dropped", 32'hFC00_1234, 1'b0, 2'd0, 1'b1, WIN2);

    // R12 round robin
    wreg(4'd2, 32'h0);
    for (int k = 0; k < 8; k++) xcheck("R12 fill", WIN2 + 32'(RRK[k]) * 32'h1000, 1'b0, 2'd0, 1'b1, WIN2);
    for (int k = 0; k < 8; k++) xcheck("R12 all hit", WIN2 + 32'(RRK[k]) * 32'h1000, 1'b0, 2'd0, 1'b0, WIN2);
    xcheck("R12 ninth", WIN2 + 32'(RRK[8]) * 32'h1000, 1'b0, 2'd0, 1'b1, WIN2);
    for (int k = 1; k < 9; k++) xcheck("R12 survivors", WIN2 + 32'(RRK[k]) * 32'h1000, 1'b0, 2'd0, 1'b0, WIN2);
    xcheck("R12 oldest evicted", WIN2 + 32'(RRK[0]) * 32'h1000, 1'b0, 2'd0, 1'b1, WIN2);

    // R13 flush in the fill cycle
    wreg(4'd2, 32'h0);
    fork
      xcheck("R13 matching page response", 32'hFC00_2000, 1'b0, 2'd0, 1'b1, WIN2);
      begin @(data_ev); reg_wr = 1'b1; reg_addr = 4'd3; reg_wdata = 32'hFC00_2000; @(negedge clk); reg_wr = 1'b0; end
    join
    xcheck("R13 matching page not kept", 32'hFC00_2000, 1'b0, 2'd0, 1'b1, WIN2);
    fork
      xcheck("R13 flush all response", 32'hFC00_4000, 1'b0, 2'd0, 1'b1, WIN2);
      begin @(data_ev); reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h0; @(negedge clk); reg_wr = 1'b0; end
    join
    xcheck("R13 flush all not kept", 32'hFC00_4000, 1'b0, 2'd0, 1'b1, WIN2);
    fork
      xcheck("R13 other page response", 32'hFC00_6000, 1'b0, 2'd0, 1'b1, WIN2);
      begin @(data_ev); reg_wr = 1'b1; reg_addr = 4'd3; reg_wdata = 32'hFC00_7000; @(negedge clk); reg_wr = 1'b0; end
    join
    xcheck("R13 other page kept", 32'hFC00_6000, 1'b0, 2'd0, 1'b0, WIN2);

    // R3 slot words
    wreg(4'd9, 32'h6);
    wreg(4'd11, 32'hFFFF_FFFF);
    rreg(4'd11, rd); chk("R3 slot3 readback", rd, 32'h0001_0007);
    rreg(4'd9, rd);  chk("R3 slot1 readback", rd, 32'h6);
    xcheck("R3 burst bits inert", 32'hFC00_6010, 1'b1, 2'd1, 1'b0, WIN2);

    // R4 bypass
    wreg(4'd10, 32'h0001_0001);
    f0 = fetches; xlate(32'h8ABC_DEF0, 1'b1, 2'd2, pa, f, c, lat);
    chk("R4 bit30 set paddr", pa, 32'h4ABC_DEF0);
    chk("R4 fault", {31'd0, f}, 32'h0);
    chk("R4 latency", lat, 1);
    chk("R4 no read", fetches - f0, 0);
    wreg(4'd10, 32'h1);
    xlate(32'hFFFF_F123, 1'b0, 2'd2, pa, f, c, lat);
    chk("R4 bit30 clear paddr", pa, 32'h3FFF_F123);
    xlate(32'h0000_1234, 1'b1, 2'd3, pa, f, c, lat);
    chk("R4 priority over window paddr", pa, 32'h4000_1234);
    chk("R4 priority over window fault", {31'd0, f}, 32'h0);

    // R5 disabled
    wreg(4'd0, 32'h8);
    f0 = fetches; xlate(32'h1234_5678, 1'b1, 2'd0, pa, f, c, lat);
    chk("R5 passthrough", pa, 32'h1234_5678);
    chk("R5 fault", {31'd0, f}, 32'h0);
    chk("R5 no read", fetches - f0, 0);

    // R6 window edges
    wreg(4'd2, 32'h0); wreg(4'd0, 32'h1D);
    xcheck("R6 code7 below", 32'h7FFF_FFFF, 1'b0, 2'd0, 1'b0, 32'h8000_0000);
    xcheck("R6 code7 first", 32'h8000_0000, 1'b0, 2'd0, 1'b1, 32'h8000_0000);
    wreg(4'd2, 32'h0); wreg(4'd0, 32'h1);
    xcheck("R6 code0 below", 32'hFEFF_FFFF, 1'b0, 2'd0, 1'b0, 32'hFF00_0000);
    xcheck("R6 code0 first", 32'hFF00_0000, 1'b0, 2'd0, 1'b1, 32'hFF00_0000);
    xcheck("R6 code0 last", 32'hFFFF_FFFF, 1'b0, 2'd0, 1'b1, 32'hFF00_0000);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule